// File: doc/BRIEF.md
# Single-Step Non-Restoring Divider

This block advances a non-restoring division by one quotient bit per command. It keeps a partial remainder, a latched divisor and three status flags that a host can read: `q` (the sign of the running remainder), `m` (the sign of the divisor) and `t` (the quotient bit just formed, which also feeds the next step). On each step the remainder moves left by one place and takes `t` into its least significant bit. The divisor is then added or subtracted, depending on the flags. The new `q` comes from the provisional sign, the carry or borrow and `m`. The new `t` is 1 exactly when `q` and `m` agree.

A host can prepare either unsigned or signed operation with an initialisation command, then issue step commands one at a time. It can also pulse `start` and let the built-in sequencer run `WIDTH` steps back to back. The sequencer collects every new `t` into a quotient shift register and flags completion with a one-cycle `done`. Correcting the final remainder, detecting a zero divisor and holding general registers are left to the surrounding logic.

Top module: `divstep_core`

## Requirements
- R1: After synchronous reset, `rem_out`, `quot_out`, `q_out`, `m_out`, `t_out`, `busy` and `done` are all zero.
- R2: The unsigned-init command (`op` = 1 with `op_valid`) loads the partial remainder from `rem_in` and latches `dsr_in` as the divisor. It clears `q`, `m` and `t`. The result is visible in the cycle after the command edge.
- R3: The signed-init command (`op` = 2) loads the remainder and divisor as in R2. It sets `q` to bit WIDTH-1 of `rem_in`, sets `m` to bit WIDTH-1 of `dsr_in`, and sets `t` to `q` XOR `m`.
- R4: A step command (`op` = 3) forms S = (remainder shifted left by one with old `t` in bit 0). When the old `q` equals `m`, the new remainder is S minus the divisor and the flag c is the borrow (S < divisor). Otherwise the new remainder is S plus the divisor and c is the carry out of bit WIDTH-1. Arithmetic is modulo 2^WIDTH.
- R5: After a step, the new `q` is P XOR c XOR `m`, where P is bit WIDTH-1 of the remainder before the step. This holds for additions and subtractions alike.
- R6: After every step, `t` is 1 exactly when the new `q` equals `m`. Steps never change `m` or the latched divisor.
- R7: A `start` pulse while idle raises `busy` in the next cycle and clears `quot_out`. It then performs exactly WIDTH steps on consecutive cycles. Each step shifts `quot_out` left by one place and puts that step's new `t` into bit 0.
- R8: `done` is high for exactly one cycle, the cycle after the edge of the last sequenced step. `busy` is already low in that cycle. The remainder, flags and quotient then hold until the next command.
- R9: Commands are ignored while `busy` is high and in a cycle where `start` is accepted. `start` is ignored while `busy` is high. `op` = 0, or `op_valid` low, leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies `op` for this cycle |
| op | input | 2 | 0 none, 1 unsigned init, 2 signed init, 3 single step |
| rem_in | input | WIDTH | Starting partial remainder for init commands |
| dsr_in | input | WIDTH | Divisor for init commands |
| start | input | 1 | Pulse to run WIDTH sequenced steps |
| rem_out | output | WIDTH | Current partial remainder |
| q_out | output | 1 | Remainder-sign flag |
| m_out | output | 1 | Divisor-sign flag |
| t_out | output | 1 | Latest quotient bit |
| quot_out | output | WIDTH | Quotient bits collected by the sequencer |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every cycle, the assertions check that the init commands leave the flags they define, that each step keeps `m` and leaves `t` equal to the agreement of `q` and `m`, and that `done` is a lone pulse with `busy` low. They also check that the newest quotient bit lands in bit 0. The choice between add and subtract and the carry-driven update of `q` depend on data values, so only the bench scenarios show them. The bench runs many init-plus-step sequences with random and boundary operands, and it confirms that all eight combinations of old `q`, `m` and `t` occur. The sequencer's run length, its quotient contents and the discarding of commands during a run are also shown only by the bench.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_INIT_U = 2'd1,
        OP_INIT_S = 2'd2,
        OP_STEP   = 2'd3
    } divop_e;

    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } flags_t;

    // quotient bit: set when remainder sign agrees with divisor sign
    function automatic logic agree_bit(input flags_t f);
        return f.q == f.m;
    endfunction

endpackage

// File: rtl/divstep_alu.sv
module divstep_alu
    import divstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] dsr_i,
    input  flags_t           flags_i,
    output logic [WIDTH-1:0] rem_o,
    output flags_t           flags_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] result;
    logic             prov_q;
    logic             subtract;
    logic             cy;
    logic             next_q;

    always_comb begin
        shifted  = {rem_i[MSB-1:0], flags_i.t};
        prov_q   = rem_i[MSB];
        subtract = (flags_i.q == flags_i.m);
        if (subtract) begin
            result = shifted - dsr_i;
            cy     = (result > shifted);
        end else begin
            result = shifted + dsr_i;
            cy     = (result < shifted);
        end

        // per-case table on (operation, divisor sign, provisional sign)
        if (subtract) begin
            if (!flags_i.m) next_q = prov_q ? ~cy : cy;
            else            next_q = prov_q ? cy  : ~cy;
        end else begin
            if (!flags_i.m) next_q = prov_q ? ~cy : cy;
            else            next_q = prov_q ? cy  : ~cy;
        end

        rem_o     = result;
        flags_o.q = next_q;
        flags_o.m = flags_i.m;
        flags_o.t = 1'b0;
        flags_o.t = agree_bit(flags_o);
    end

endmodule

// File: rtl/divstep_seq.sv
module divstep_seq #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            cnt    <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o && start_i) begin
                busy_o <= 1'b1;
                cnt    <= '0;
            end else if (busy_o) begin
                if (cnt == LAST) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/divstep_qreg.sv
module divstep_qreg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] quot_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            quot_o <= '0;
        end else if (shift_i) begin
            quot_o <= {quot_o[WIDTH-2:0], bit_i};
        end
    end

    assert_qbit_lsb_R7: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !clear_i) |=> (quot_o[0] == $past(bit_i)));

    assert_qclear_R7: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (quot_o == '0));

endmodule

// File: rtl/divstep_core.sv
module divstep_core
    import divstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] rem_in,
    input  logic [WIDTH-1:0] dsr_in,
    input  logic             start,
    output logic [WIDTH-1:0] rem_out,
    output logic             q_out,
    output logic             m_out,
    output logic             t_out,
    output logic [WIDTH-1:0] quot_out,
    output logic             busy,
    output logic             done
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] rem_r;
    logic [WIDTH-1:0] dsr_r;
    flags_t           flags_r;
    logic [WIDTH-1:0] alu_rem;
    flags_t           alu_flags;
    logic             seq_busy;
    logic             start_go;
    logic             op_take;
    logic             step_en;
    divop_e           op_kind;

    assign op_kind  = divop_e'(op);
    assign start_go = start && !seq_busy;
    assign op_take  = op_valid && !seq_busy && !start;
    assign step_en  = seq_busy || (op_take && op_kind == OP_STEP);

    divstep_alu #(.WIDTH(WIDTH)) u_alu (
        .rem_i   (rem_r),
        .dsr_i   (dsr_r),
        .flags_i (flags_r),
        .rem_o   (alu_rem),
        .flags_o (alu_flags)
    );

    divstep_seq #(.WIDTH(WIDTH)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .busy_o  (seq_busy),
        .done_o  (done)
    );

    divstep_qreg #(.WIDTH(WIDTH)) u_qreg (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_go),
        .shift_i (seq_busy),
        .bit_i   (alu_flags.t),
        .quot_o  (quot_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_r   <= '0;
            dsr_r   <= '0;
            flags_r <= '0;
        end else if (step_en) begin
            rem_r   <= alu_rem;
            flags_r <= alu_flags;
        end else if (op_take) begin
            case (op_kind)
                OP_INIT_U: begin
                    rem_r   <= rem_in;
                    dsr_r   <= dsr_in;
                    flags_r <= '0;
                end
                OP_INIT_S: begin
                    rem_r     <= rem_in;
                    dsr_r     <= dsr_in;
                    flags_r.q <= rem_in[MSB];
                    flags_r.m <= dsr_in[MSB];
                    flags_r.t <= rem_in[MSB] ^ dsr_in[MSB];
                end
                default: ;
            endcase
        end
    end

    assign rem_out = rem_r;
    assign q_out   = flags_r.q;
    assign m_out   = flags_r.m;
    assign t_out   = flags_r.t;
    assign busy    = seq_busy;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rem_out == '0 && quot_out == '0 && !q_out && !m_out
                        && !t_out && !busy && !done));

    assert_init_u_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (op_take && op_kind == OP_INIT_U) |=>
            (!q_out && !m_out && !t_out && rem_out == $past(rem_in)));

    assert_init_s_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (op_take && op_kind == OP_INIT_S) |=>
            (q_out == $past(rem_in[MSB]) && m_out == $past(dsr_in[MSB])
             && t_out == (q_out ^ m_out)));

    assert_step_t_R6: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (t_out == (q_out == m_out) && $stable(m_out)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!seq_busy && !start && (!op_valid || op_kind == OP_NONE)) |=>
            ($stable(rem_out) && $stable(q_out) && $stable(t_out)));

endmodule

// File: tb/divstep_core_bench.sv
module divstep_core_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [1:0]   op;
    logic [W-1:0] rem_in;
    logic [W-1:0] dsr_in;
    logic         start;
    logic [W-1:0] rem_out;
    logic         q_out, m_out, t_out;
    logic [W-1:0] quot_out;
    logic         busy, done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference state
    logic [W-1:0] mrem, mdsr, mquot;
    logic         mq, mm, mt;
    bit           seen [8];

    always #10 clk = ~clk;

    divstep_core #(.WIDTH(W)) u_divstep_core (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op),
        .rem_in(rem_in), .dsr_in(dsr_in), .start(start),
        .rem_out(rem_out), .q_out(q_out), .m_out(m_out), .t_out(t_out),
        .quot_out(quot_out), .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " rem"}, 64'(rem_out), 64'(mrem));
        check({req, " flags"}, 64'({q_out, m_out, t_out}), 64'({mq, mm, mt}));
    endtask

    // arithmetic reference of one step
    task automatic model_step();
        logic [W-1:0] sh;
        logic [W:0]   wide;
        logic         p, c;
        seen[{mq, mm, mt}] = 1;
        sh = {mrem[W-2:0], mt};
        p  = mrem[W-1];
        if (mq == mm) wide = {1'b0, sh} - {1'b0, mdsr};
        else          wide = {1'b0, sh} + {1'b0, mdsr};
        c    = wide[W];
        mrem = wide[W-1:0];
        mq   = p ^ c ^ mm;
        mt   = ~(mq ^ mm);
    endtask

    task automatic model_init(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b);
        mrem = a; mdsr = b;
        if (sgn) begin mq = a[W-1]; mm = b[W-1]; mt = a[W-1] ^ b[W-1]; end
        else     begin mq = 0; mm = 0; mt = 0; end
    endtask

    task automatic issue(input logic [1:0] code, input logic [W-1:0] a, input logic [W-1:0] b);
        op_valid = 1; op = code; rem_in = a; dsr_in = b;
        @(negedge clk);
        op_valid = 0; op = 0;
    endtask

    function automatic logic [W-1:0] pick(input int k);
        case (k % 5)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            default: return W'($urandom);
        endcase
    endfunction

    task automatic run_seq(input bit disturb, input string req);
        // start accepted at this negedge-to-negedge window
        start = 1;
        @(negedge clk);
        start = 0;
        mquot = '0;
        check({req, " busy after start"}, 64'(busy), 64'd1);
        check({req, " quot cleared"}, 64'(quot_out), 64'd0);
        for (int i = 0; i < W; i++) begin
            if (disturb && i == 4) begin op_valid = 1; op = 2'd1; rem_in = 32'h1234_5678; dsr_in = 32'h5; end
            if (disturb && i == 9) start = 1;
            @(negedge clk);
            op_valid = 0; op = 0; start = 0;
            model_step();
            mquot = {mquot[W-2:0], mt};
            if (i < W - 1) begin
                checks++;
                if (busy !== 1'b1 || done !== 1'b0) begin
                    failures++;
                    $display("FAIL R7 busy/done mid-run actual=%b%b expected=10", busy, done);
                end
            end
        end
        check({req, " R8 done"}, 64'(done), 64'd1);
        check({req, " R8 busy low"}, 64'(busy), 64'd0);
        check({req, " R7 quotient"}, 64'(quot_out), 64'(mquot));
        check_state({req, " R4 sequenced"});
        @(negedge clk);
        check({req, " R8 done single"}, 64'(done), 64'd0);
        check_state({req, " R8 hold"});
        check({req, " R8 quot hold"}, 64'(quot_out), 64'(mquot));
    endtask

    initial begin
        rst = 1; op_valid = 0; op = 0; rem_in = 0; dsr_in = 0; start = 0;
        mrem = 0; mdsr = 0; mq = 0; mm = 0; mt = 0; mquot = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 rem", 64'(rem_out), 64'd0);
        check("R1 quot", 64'(quot_out), 64'd0);
        check("R1 flags/busy/done", 64'({q_out, m_out, t_out, busy, done}), 64'd0);

        // R2 / R3 init
        issue(2'd1, 32'hC000_0001, 32'h8000_0003);
        model_init(0, 32'hC000_0001, 32'h8000_0003);
        check_state("R2 unsigned init");
        issue(2'd2, 32'hC000_0001, 32'h0000_0003);
        model_init(1, 32'hC000_0001, 32'h0000_0003);
        check_state("R3 signed init neg/pos");
        issue(2'd2, 32'h4000_0001, 32'h8000_0003);
        model_init(1, 32'h4000_0001, 32'h8000_0003);
        check_state("R3 signed init pos/neg");

        // R9 no-op codes
        issue(2'd0, 32'hDEAD_BEEF, 32'h1);
        check_state("R9 op none");
        op = 2'd3; @(negedge clk); op = 0;
        check_state("R9 op_valid low");

        // R4 R5 R6 sweep of init + step sequences
        for (int s = 0; s < 400; s++) begin
            logic [W-1:0] a, b;
            bit sg;
            a = pick(int'($urandom % 7));
            b = pick(int'($urandom % 7));
            sg = s[0];
            issue(sg ? 2'd2 : 2'd1, a, b);
            model_init(sg, a, b);
            for (int k = 0; k < 6; k++) begin
                issue(2'd3, 32'hFFFF_0000, 32'h0000_FFFF);
                model_step();
                check_state("R4 R5 R6 step");
            end
        end
        for (int c = 0; c < 8; c++)
            check("R5 flag combination covered", 64'(seen[c]), 64'd1);

        // R7 R8 sequencer, unsigned and signed
        issue(2'd1, 32'h0000_0007, 32'h0000_0003);
        model_init(0, 32'h0000_0007, 32'h0000_0003);
        run_seq(0, "R7 unsigned run");
        issue(2'd2, 32'hFFFF_FFF0, 32'h0000_0005);
        model_init(1, 32'hFFFF_FFF0, 32'h0000_0005);
        run_seq(0, "R7 signed run");

        // R9 commands and start during busy are dropped
        issue(2'd1, 32'h0123_4567, 32'h89AB_CDEF);
        model_init(0, 32'h0123_4567, 32'h89AB_CDEF);
        run_seq(1, "R9 disturbed run");

        // R9 start wins over simultaneous command
        issue(2'd2, 32'h8765_4321, 32'h0000_0011);
        model_init(1, 32'h8765_4321, 32'h0000_0011);
        op_valid = 1; op = 2'd1; rem_in = 32'h0; dsr_in = 32'h0;
        run_seq(0, "R9 start with command");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        finished = 1;
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule